// File: doc/BRIEF.md
# Console Register Window

This block is a peripheral on a 32-bit load/store bus. It claims the top 64 KB of the address space for console I/O, and any access whose upper sixteen address bits are all ones is answered here rather than by main memory. Inside that window four word registers connect a processor to a keyboard-side byte producer and a display-side byte consumer. Each side uses a valid/ready handshake.

Software busy-polls a status word until its least significant bit is set. For input it then loads the received character. For output it then stores the character to send. Reading a received character frees the input slot. Storing a character occupies the output slot until the display takes it. Reads are answered in the same cycle, and the flags move on the next clock edge.

Top module: `consoleMmio`

## Requirements
- R1: An access (read or write) whose address bits 31:16 are not 16'hFFFF asserts `memSelect` in the same cycle and leaves every register unchanged. An access inside the window never asserts `memSelect`, and `memSelect` is low when there is no access.
- R2: Word reads inside the window are answered combinationally in the same cycle. Offset 0x0 returns the input-full flag in bit 0. Offset 0x8 returns the output-free flag in bit 0, which is 1 when no byte is waiting for the display. Offset 0xC reads as zero. All other bits of these words are zero. `busRdata` is zero whenever no in-window read is made.
- R3: `kbdReady` is high exactly when the input slot is empty. A cycle with `kbdValid` and `kbdReady` both high stores `kbdData` and sets the input-full flag at the next edge.
- R4: A read at offset 0x4 returns the stored byte zero-extended to 32 bits, and it clears the input-full flag at the next edge. If a byte is accepted in the same cycle, the accept wins.
- R5: A write at offset 0xC while the output slot is free stores `busWdata[7:0]`. From the next cycle, `dispValid` is high with that byte on `dispData`, and offset 0x8 reads 0.
- R6: A cycle with `dispValid` and `dispReady` both high frees the output slot at the next edge. `dispValid` then drops and offset 0x8 reads 1.
- R7: A write at offset 0xC while a byte is still waiting for the display is ignored. `dispData` stays stable and `dispValid` stays high until the display accepts.
- R8: Writes at offsets 0x0, 0x4 and 0x8 change no flag and no stored byte.
- R9: Reads at any other in-window address, including unaligned ones, return zero. Writes there have no effect.
- R10: A synchronous reset empties the input slot, frees the output slot and clears both stored bytes. After reset `kbdReady` is 1, `dispValid` is 0, offset 0x0 reads 0 and offset 0x8 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | 32 | Byte address of the bus access |
| busRead | input | 1 | Read strobe for this cycle |
| busWrite | input | 1 | Write strobe for this cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, same cycle as `busRead` |
| memSelect | output | 1 | Access lies outside the window and goes to memory |
| kbdValid | input | 1 | Keyboard side offers a byte |
| kbdData | input | 8 | Offered keyboard byte |
| kbdReady | output | 1 | Input slot is empty and takes a byte |
| dispValid | output | 1 | A byte waits for the display |
| dispData | output | 8 | Byte for the display |
| dispReady | input | 1 | Display takes the byte this cycle |

## Verification
The block is tried with polling loops. In these loops, software spins on each status word and then moves a character, which shows that the flags rise and fall on the edges that software depends on. A keyboard that keeps its valid signal high while the slot is full, and a display that stalls for several cycles, separate correct back-pressure from bytes that are lost or overwritten. Stray writes to status and input words, reads at unused and unaligned window addresses, and accesses just below the window test the decode boundary. A burst of queued keystrokes echoed back at full speed tests the case where a read clears the flag and the next byte is accepted on the following edge.

// File: rtl/console_pkg.sv
package console_pkg;

  // Register slots inside the window, indexed by address bits 3:2.
  localparam int SLOT_COUNT    = 4;
  localparam int SLOT_IN_CTL   = 0;
  localparam int SLOT_IN_DATA  = 1;
  localparam int SLOT_OUT_CTL  = 2;
  localparam int SLOT_OUT_DATA = 3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IN_CTL,
    SEL_IN_DATA,
    SEL_OUT_CTL,
    SEL_OUT_DATA
  } regSel_e;

  // Strobes sent from the control to the datapath, one set per cycle.
  typedef struct packed {
    regSel_e rdSel;      // which word drives the read bus
    logic    kbdAccept;  // keyboard byte is taken this cycle
    logic    inTake;     // CPU consumes the input byte
    logic    outLoad;    // CPU stores a byte for the display
    logic    dispDone;   // display takes the waiting byte
  } consoleStrb_t;

endpackage

// File: rtl/console_ctrl.sv
module console_ctrl
  import console_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 16,
  parameter logic [WIN_BITS-1:0] WIN_TAG = '1
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic              kbdValid,
  input  logic              dispReady,
  input  logic              inFull,
  input  logic              outPending,
  output consoleStrb_t      strb,
  output logic              memSelect,
  output logic              kbdReady,
  output logic              dispValid
);

  localparam int OFF_W = ADDR_W - WIN_BITS;

  logic              winHit;
  logic [OFF_W-1:0]  offset;
  logic              aligned;
  logic [1:0]        slotIdx;
  logic [SLOT_COUNT-1:0] slotHit;

  assign winHit  = (busAddr[ADDR_W-1 -: WIN_BITS] == WIN_TAG);
  assign offset  = busAddr[OFF_W-1:0];
  assign aligned = (offset[OFF_W-1:4] == '0) && (offset[1:0] == 2'b00);
  assign slotIdx = offset[3:2];

  for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_slot
    assign slotHit[s] = winHit && aligned && (slotIdx == s[1:0]);
  end

  assign memSelect = (busRead || busWrite) && !winHit;
  assign kbdReady  = !inFull;
  assign dispValid = outPending;

  always_comb begin
    strb           = '0;
    strb.rdSel     = SEL_NONE;
    strb.kbdAccept = kbdValid && !inFull;
    strb.inTake    = busRead && slotHit[SLOT_IN_DATA];
    strb.outLoad   = busWrite && slotHit[SLOT_OUT_DATA] && !outPending;
    strb.dispDone  = dispReady && outPending;
    if (busRead) begin
      unique case (1'b1)
        slotHit[SLOT_IN_CTL]:   strb.rdSel = SEL_IN_CTL;
        slotHit[SLOT_IN_DATA]:  strb.rdSel = SEL_IN_DATA;
        slotHit[SLOT_OUT_CTL]:  strb.rdSel = SEL_OUT_CTL;
        slotHit[SLOT_OUT_DATA]: strb.rdSel = SEL_OUT_DATA;
        default:                strb.rdSel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/console_dpath.sv
module console_dpath
  import console_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  consoleStrb_t      strb,
  input  logic [CHAR_W-1:0] kbdData,
  input  logic [DATA_W-1:0] busWdata,
  output logic              inFull,
  output logic              outPending,
  output logic [CHAR_W-1:0] outByte,
  output logic [DATA_W-1:0] busRdata
);

  localparam int PAD_W = DATA_W - CHAR_W;

  logic [CHAR_W-1:0] inByte;

  always_ff @(posedge clk) begin
    if (rst) begin
      inFull <= 1'b0;
      inByte <= '0;
    end else if (strb.kbdAccept) begin
      inFull <= 1'b1;
      inByte <= kbdData;
    end else if (strb.inTake) begin
      inFull <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outPending <= 1'b0;
      outByte    <= '0;
    end else if (strb.dispDone) begin
      outPending <= 1'b0;
    end else if (strb.outLoad) begin
      outPending <= 1'b1;
      outByte    <= busWdata[CHAR_W-1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (strb.rdSel)
      SEL_IN_CTL:  busRdata[0] = inFull;
      SEL_IN_DATA: busRdata    = {{PAD_W{1'b0}}, inByte};
      SEL_OUT_CTL: busRdata[0] = !outPending;
      default:     busRdata    = '0;
    endcase
  end

endmodule

// File: rtl/consoleMmio.sv
module consoleMmio
  import console_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int CHAR_W   = 8,
  parameter int WIN_BITS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              memSelect,
  input  logic              kbdValid,
  input  logic [CHAR_W-1:0] kbdData,
  output logic              kbdReady,
  output logic              dispValid,
  output logic [CHAR_W-1:0] dispData,
  input  logic              dispReady
);

  consoleStrb_t strb;
  logic         inFull;
  logic         outPending;

  console_ctrl #(
    .ADDR_W  (ADDR_W),
    .WIN_BITS(WIN_BITS),
    .WIN_TAG ({WIN_BITS{1'b1}})
  ) u_ctrl (
    .busAddr   (busAddr),
    .busRead   (busRead),
    .busWrite  (busWrite),
    .kbdValid  (kbdValid),
    .dispReady (dispReady),
    .inFull    (inFull),
    .outPending(outPending),
    .strb      (strb),
    .memSelect (memSelect),
    .kbdReady  (kbdReady),
    .dispValid (dispValid)
  );

  console_dpath #(
    .DATA_W(DATA_W),
    .CHAR_W(CHAR_W)
  ) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .kbdData   (kbdData),
    .busWdata  (busWdata),
    .inFull    (inFull),
    .outPending(outPending),
    .outByte   (dispData),
    .busRdata  (busRdata)
  );

endmodule

// File: rtl/console_checker.sv
module console_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRead,
  input logic              busWrite,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              memSelect,
  input logic              kbdValid,
  input logic              kbdReady,
  input logic              dispValid,
  input logic [CHAR_W-1:0] dispData,
  input logic              dispReady
);

  logic inWin;
  logic isUsed;
  assign inWin  = (busAddr[ADDR_W-1 -: 16] == 16'hFFFF);
  assign isUsed = (busAddr[15:0] == 16'h0000) || (busAddr[15:0] == 16'h0004) ||
                  (busAddr[15:0] == 16'h0008) || (busAddr[15:0] == 16'h000C);

  AST_WINDOW_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    inWin |-> !memSelect);  // R1

  AST_OUT_FLAG_READ: assert property (@(posedge clk) disable iff (rst)
    (busRead && busAddr == 32'hFFFF0008) |-> (busRdata == {31'b0, !dispValid}));  // R2

  AST_KBD_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (kbdValid && kbdReady) |=> !kbdReady);  // R3

  AST_READ_FREES: assert property (@(posedge clk) disable iff (rst)
    (busRead && busAddr == 32'hFFFF0004 && !kbdReady) |=> kbdReady);  // R4

  AST_SEND_START: assert property (@(posedge clk) disable iff (rst)
    (busWrite && busAddr == 32'hFFFF000C && !dispValid) |=>
      (dispValid && dispData == $past(busWdata[CHAR_W-1:0])));  // R5

  AST_SINK_DONE: assert property (@(posedge clk) disable iff (rst)
    (dispValid && dispReady) |=> !dispValid);  // R6

  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (rst)
    (dispValid && !dispReady) |=> (dispValid && $stable(dispData)));  // R7

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (busRead && inWin && !isUsed) |-> (busRdata == '0));  // R9

endmodule

bind consoleMmio console_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .CHAR_W(CHAR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busAddr  (busAddr),
  .busRead  (busRead),
  .busWrite (busWrite),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .memSelect(memSelect),
  .kbdValid (kbdValid),
  .kbdReady (kbdReady),
  .dispValid(dispValid),
  .dispData (dispData),
  .dispReady(dispReady)
);

// File: tb/test_consoleMmio.sv
module test_consoleMmio;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] busAddr = '0;
  logic        busRead = 1'b0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        memSelect;
  logic        kbdValid = 1'b0;
  logic [7:0]  kbdData = '0;
  logic        kbdReady;
  logic        dispValid;
  logic [7:0]  dispData;
  logic        dispReady = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Behavioural reference state.
  bit       mIn = 0;
  bit [7:0] mInByte = 0;
  bit       mPend = 0;
  bit [7:0] mOutByte = 0;
  byte unsigned keyQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  consoleMmio i_consoleMmio (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busRead(busRead),
    .busWrite(busWrite), .busWdata(busWdata), .busRdata(busRdata),
    .memSelect(memSelect), .kbdValid(kbdValid), .kbdData(kbdData),
    .kbdReady(kbdReady), .dispValid(dispValid), .dispData(dispData),
    .dispReady(dispReady)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expRdata();
    logic hit;
    hit = (busAddr[31:16] == 16'hFFFF);
    if (!(busRead && hit)) return 32'h0;
    case (busAddr[15:0])
      16'h0000: return {31'b0, mIn};
      16'h0004: return {24'b0, mInByte};
      16'h0008: return {31'b0, !mPend};
      default:  return 32'h0;
    endcase
  endfunction

  // Compare every output, pass one edge, advance the model.
  task automatic cycle(input string tag);
    bit hit;
    #1;
    hit = (busAddr[31:16] == 16'hFFFF);
    chk(tag, "busRdata", busRdata, expRdata());
    chk("R1", "memSelect", {31'b0, memSelect}, {31'b0, (busRead || busWrite) && !hit});
    chk("R3", "kbdReady", {31'b0, kbdReady}, {31'b0, !mIn});
    chk(tag, "dispValid", {31'b0, dispValid}, {31'b0, mPend});
    chk(tag, "dispData", {24'b0, dispData}, {24'b0, mOutByte});
    @(posedge clk);
    if (rst) begin
      mIn = 0; mInByte = 0; mPend = 0; mOutByte = 0;
    end else begin
      if (kbdValid && !mIn) begin
        mIn = 1; mInByte = kbdData;
      end else if (busRead && hit && busAddr[15:0] == 16'h0004) begin
        mIn = 0;
      end
      if (mPend && dispReady) begin
        mPend = 0;
      end else if (!mPend && busWrite && hit && busAddr[15:0] == 16'h000C) begin
        mPend = 1; mOutByte = busWdata[7:0];
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    busRead = 0; busWrite = 0;
    for (int i = 0; i < n; i++) cycle(tag);
  endtask

  task automatic rd(input logic [31:0] a, input string tag);
    busAddr = a; busRead = 1; busWrite = 0;
    cycle(tag);
    busRead = 0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input string tag);
    busAddr = a; busWdata = d; busRead = 0; busWrite = 1;
    cycle(tag);
    busWrite = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    if (!done) $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    idle(2, "R10");
    rst = 0;
    // R10: reset values seen at the ports
    rd(32'hFFFF0000, "R10");
    rd(32'hFFFF0008, "R10");
    rd(32'hFFFF0004, "R10");

    // R1: addresses outside the window, including just below it
    rd(32'h0000_1000, "R1");
    wr(32'h8000_0000, 32'h0000_0055, "R1");
    rd(32'hFFFE_FFFC, "R1");
    wr(32'hFFFE_FFFC, 32'h0000_0066, "R1");

    // R3: one keystroke, then software polls
    kbdValid = 1; kbdData = 8'h41;
    cycle("R3");
    kbdValid = 0;
    rd(32'hFFFF0000, "R2");
    // keyboard holds a new byte while the slot is full
    kbdValid = 1; kbdData = 8'h42;
    idle(3, "R3");
    rd(32'hFFFF0004, "R4");      // returns 0x41, frees slot
    cycle("R3");                 // 0x42 accepted here
    kbdValid = 0;
    rd(32'hFFFF0000, "R2");
    rd(32'hFFFF0004, "R4");
    rd(32'hFFFF0000, "R4");

    // R8: stray writes to status and input words
    kbdValid = 1; kbdData = 8'h5A;
    cycle("R3");
    kbdValid = 0;
    wr(32'hFFFF0000, 32'h0000_0000, "R8");
    wr(32'hFFFF0004, 32'h0000_00EE, "R8");
    wr(32'hFFFF0008, 32'h0000_0000, "R8");
    rd(32'hFFFF0000, "R8");
    rd(32'hFFFF0004, "R8");
    rd(32'hFFFF0008, "R8");

    // R5 and R7: display stalls
    dispReady = 0;
    wr(32'hFFFF000C, 32'hDEAD_BE55, "R5");
    rd(32'hFFFF0008, "R5");
    wr(32'hFFFF000C, 32'h0000_0077, "R7");
    idle(3, "R7");
    rd(32'hFFFF000C, "R2");
    // R6: display takes the byte
    dispReady = 1;
    cycle("R6");
    dispReady = 0;
    rd(32'hFFFF0008, "R6");
    wr(32'hFFFF000C, 32'h0000_0031, "R5");
    dispReady = 1;
    cycle("R6");
    idle(1, "R6");

    // R9: unused and unaligned window addresses
    rd(32'hFFFF0010, "R9");
    rd(32'hFFFF0002, "R9");
    rd(32'hFFFF8000, "R9");
    rd(32'hFFFFFFFC, "R9");
    wr(32'hFFFF0010, 32'h0000_00AA, "R9");
    wr(32'hFFFF000D, 32'h0000_00AB, "R9");
    rd(32'hFFFF0008, "R9");

    // Burst: queued keystrokes echoed at full speed
    keyQ = '{8'h68, 8'h65, 8'h6C, 8'h6C, 8'h6F};
    dispReady = 1;
    while (keyQ.size() > 0) begin
      kbdValid = 1; kbdData = keyQ.pop_front();
      cycle("R3");
      kbdValid = 0;
      for (int p = 0; p < 4 && !mIn; p++) rd(32'hFFFF0000, "R2");
      rd(32'hFFFF0004, "R4");
      for (int p = 0; p < 4 && mPend; p++) rd(32'hFFFF0008, "R6");
      wr(32'hFFFF000C, {24'b0, mInByte}, "R5");
    end
    idle(2, "R6");

    // R10: reset in the middle of traffic
    dispReady = 0;
    kbdValid = 1; kbdData = 8'h99;
    cycle("R3");
    kbdValid = 0;
    wr(32'hFFFF000C, 32'h0000_0012, "R5");
    rst = 1;
    cycle("R10");
    rst = 0;
    rd(32'hFFFF0000, "R10");
    rd(32'hFFFF0008, "R10");
    rd(32'hFFFF0004, "R10");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule